// File: doc/BRIEF.md
# Bit-Test Branch Bus Sequencer

This block runs the memory-read cycles of a bit-test-and-branch instruction once the opcode byte has already been fetched. A start strobe passes in the opcode and the program counter, which points at the first operand byte. The sequencer then drives one read per clock:

- fetch the zero-page address byte;
- read the data byte at that zero-page location;
- read the same location again, as a stall while the decision settles;
- fetch the signed branch offset;
- on a taken branch, make one or two dummy reads at the fall-through address.

The opcode selects the bit to test and whether that bit must be clear or set for the branch to be taken. When the last bus cycle is done, the block pulses a done flag for one clock. With it come the resulting program counter and the instruction's total cycle count, which includes the opcode cycle. There are three possible lengths:

- five cycles when the branch is not taken;
- six cycles when it is taken within the same page;
- seven cycles when the target lies on a different page from the fall-through address.

Top module: `bitBranchSeq`

## Requirements
- R1: After synchronous reset the block is idle: busRead, busWrite, busy and done are all 0.
- R2: While idle, a start strobe whose opcode low nibble is not 0xF is ignored: no read is issued and done never pulses.
- R3: After an accepted start with program counter P, the read addresses on successive clocks are P, then {0x00, Z} twice (Z is the byte read at P), then P+1.
- R4: Opcode bits 6:4 select the tested bit of the zero-page data byte. Opcode bit 7 = 0 takes the branch when that bit is 0, and bit 7 = 1 takes it when that bit is 1.
- R5: A branch that is not taken ends after 5 cycles with donePc = P+2.
- R6: A taken branch reads the fall-through address P+2 once more. It then ends with donePc = P+2 plus the sign-extended offset, and a count of 6 when the target's high byte equals that of P+2.
- R7: A taken branch whose target high byte differs from that of P+2 reads P+2 twice and reports a count of 7.
- R8: The target uses 16-bit arithmetic with wrap-around, including negative offsets and carries past 0xFFFF.
- R9: While busy the block asserts busRead on every clock, and it never asserts busWrite.
- R10: done is high for exactly one clock, in the clock after the last read. Its doneCycles is 5, 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startValid | input | 1 | Start strobe, sampled while idle |
| startOpcode | input | 8 | Opcode of the instruction being run |
| startPc | input | 16 | Address of the first operand byte |
| busAddr | output | 16 | Read address |
| busRead | output | 1 | Read strobe |
| busWrite | output | 1 | Write strobe, always 0 |
| busRdata | input | 8 | Read data, sampled on the rising edge that ends the cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-clock completion pulse |
| doneCycles | output | 3 | Total instruction cycles, valid with done |
| donePc | output | 16 | Next program counter, valid with done |

## Verification
The bench targets four kinds of error:

- **Bit selection and polarity.** It sweeps every bit number under both polarities. A design that took the bit number or the polarity from the wrong opcode field would branch when it should fall through.
- **Page crossings.** Branches go forward and backward across a page edge and wrap past 0xFFFF. A sequencer that compared against the wrong high byte, or used 8-bit target arithmetic, would end a cycle early or late, or report a wrong address.
- **Rejected opcodes.** A start with a non-matching opcode must cause no bus activity at all.
- **Address trace.** The reads are checked in order, so a dropped stall read or a dummy read at the wrong address shows up.

// File: rtl/bitBranchPkg.sv
package bitBranchPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ZPADDR,
    ST_ZPREAD,
    ST_ZPSTALL,
    ST_OFFSET,
    ST_DUMMY1,
    ST_DUMMY2
  } seqState_t;

  typedef enum logic [1:0] {
    ADDR_PC,
    ADDR_ZP,
    ADDR_FALL
  } addrSel_t;

  // strobes from control to datapath, one set per clock
  typedef struct packed {
    logic     capture;
    logic     loadZp;
    logic     loadData;
    logic     loadOffset;
    logic     step;
    logic     finish;
    logic     busRead;
    addrSel_t addrSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/bitBranchCtrl.sv
module bitBranchCtrl
  import bitBranchPkg::*;
#(
  parameter logic [3:0] OP_NIBBLE = 4'hF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        startValid,
  input  logic [3:0]  startNib,
  input  logic        taken,
  input  logic        crossPage,
  output ctrlStrobe_t strb,
  output logic        busy
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  always_comb begin
    stateNext       = state;
    strb            = '0;
    strb.addrSel    = ADDR_PC;
    unique case (state)
      ST_IDLE: begin
        if (startValid && (startNib == OP_NIBBLE)) begin
          strb.capture = 1'b1;
          stateNext    = ST_ZPADDR;
        end
      end
      ST_ZPADDR: begin
        strb.busRead = 1'b1;
        strb.addrSel = ADDR_PC;
        strb.loadZp  = 1'b1;
        strb.step    = 1'b1;
        stateNext    = ST_ZPREAD;
      end
      ST_ZPREAD: begin
        strb.busRead  = 1'b1;
        strb.addrSel  = ADDR_ZP;
        strb.loadData = 1'b1;
        strb.step     = 1'b1;
        stateNext     = ST_ZPSTALL;
      end
      ST_ZPSTALL: begin
        strb.busRead = 1'b1;
        strb.addrSel = ADDR_ZP;
        strb.step    = 1'b1;
        stateNext    = ST_OFFSET;
      end
      ST_OFFSET: begin
        strb.busRead    = 1'b1;
        strb.addrSel    = ADDR_PC;
        strb.loadOffset = 1'b1;
        strb.step       = 1'b1;
        if (taken) begin
          stateNext = ST_DUMMY1;
        end else begin
          strb.finish = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      ST_DUMMY1: begin
        strb.busRead = 1'b1;
        strb.addrSel = ADDR_FALL;
        strb.step    = 1'b1;
        if (crossPage) begin
          stateNext = ST_DUMMY2;
        end else begin
          strb.finish = 1'b1;
          stateNext   = ST_IDLE;
        end
      end
      ST_DUMMY2: begin
        strb.busRead = 1'b1;
        strb.addrSel = ADDR_FALL;
        strb.step    = 1'b1;
        strb.finish  = 1'b1;
        stateNext    = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R2: a non-matching start leaves the sequencer idle
  assert_ignore_start_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && startValid && startNib != OP_NIBBLE) |=> (state == ST_IDLE));

  // R7: the second dummy read only follows the first on a page crossing
  assert_second_dummy_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DUMMY2) |-> ($past(state) == ST_DUMMY1 && $past(crossPage)));

endmodule

// File: rtl/bitBranchPath.sv
module bitBranchPath
  import bitBranchPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strb,
  input  logic [DATA_W-1:0] startOpcode,
  input  logic [ADDR_W-1:0] startPc,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] busAddr,
  output logic              taken,
  output logic              crossPage,
  output logic              done,
  output logic [CNT_W-1:0]  doneCycles,
  output logic [ADDR_W-1:0] donePc
);

  localparam int BIT_SEL_W = $clog2(DATA_W);
  localparam int HIGH_W    = ADDR_W - DATA_W;
  localparam int SEL_LSB   = 4;

  logic [ADDR_W-1:0] pcReg, fallReg;
  logic [DATA_W-1:0] opReg, zpReg, dataReg;
  logic [CNT_W-1:0]  cycleCnt;
  logic              doneReg;

  logic [BIT_SEL_W-1:0] bitSel;
  logic                 wantSet;
  logic [ADDR_W-1:0]    pcPlusOne, offsetExt, branchTarget, zpAddr;

  assign bitSel       = opReg[SEL_LSB +: BIT_SEL_W];
  assign wantSet      = opReg[DATA_W-1];
  assign taken        = (dataReg[bitSel] == wantSet);
  assign pcPlusOne    = pcReg + 1'b1;
  assign offsetExt    = {{HIGH_W{busRdata[DATA_W-1]}}, busRdata};
  assign branchTarget = pcPlusOne + offsetExt;
  assign zpAddr       = {{HIGH_W{1'b0}}, zpReg};
  assign crossPage    = (pcReg[ADDR_W-1:DATA_W] != fallReg[ADDR_W-1:DATA_W]);

  always_comb begin
    unique case (strb.addrSel)
      ADDR_ZP:   busAddr = zpAddr;
      ADDR_FALL: busAddr = fallReg;
      default:   busAddr = pcReg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcReg    <= '0;
      fallReg  <= '0;
      opReg    <= '0;
      zpReg    <= '0;
      dataReg  <= '0;
      cycleCnt <= '0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= strb.finish;
      if (strb.capture) begin
        pcReg    <= startPc;
        opReg    <= startOpcode;
        cycleCnt <= CNT_W'(1);
      end else begin
        if (strb.step) cycleCnt <= cycleCnt + 1'b1;
        if (strb.loadZp) begin
          zpReg <= busRdata;
          pcReg <= pcPlusOne;
        end else if (strb.loadOffset) begin
          fallReg <= pcPlusOne;
          pcReg   <= taken ? branchTarget : pcPlusOne;
        end
        if (strb.loadData) dataReg <= busRdata;
      end
    end
  end

  assign done       = doneReg;
  assign doneCycles = cycleCnt;
  assign donePc     = pcReg;

  // R10: completion lasts one clock
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    doneReg |=> !doneReg);

  // R10: reported length is one of the three legal values
  assert_done_count_R10: assert property (@(posedge clk) disable iff (rst)
    doneReg |-> (cycleCnt >= CNT_W'(5) && cycleCnt <= CNT_W'(7)));

  // R3: every bus cycle adds exactly one to the count
  assert_step_count_R3: assert property (@(posedge clk) disable iff (rst)
    (strb.step && !strb.capture) |=> (cycleCnt == $past(cycleCnt) + 1'b1));

endmodule

// File: rtl/bitBranchSeq.sv
module bitBranchSeq
  import bitBranchPkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startValid,
  input  logic [DATA_W-1:0] startOpcode,
  input  logic [ADDR_W-1:0] startPc,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busRead,
  output logic              busWrite,
  input  logic [DATA_W-1:0] busRdata,
  output logic              busy,
  output logic              done,
  output logic [CNT_W-1:0]  doneCycles,
  output logic [ADDR_W-1:0] donePc
);

  ctrlStrobe_t strb;
  logic        taken, crossPage;

  bitBranchCtrl #(.OP_NIBBLE(4'hF)) ctrl (
    .clk(clk), .rst(rst),
    .startValid(startValid), .startNib(startOpcode[3:0]),
    .taken(taken), .crossPage(crossPage),
    .strb(strb), .busy(busy)
  );

  bitBranchPath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) path (
    .clk(clk), .rst(rst), .strb(strb),
    .startOpcode(startOpcode), .startPc(startPc), .busRdata(busRdata),
    .busAddr(busAddr), .taken(taken), .crossPage(crossPage),
    .done(done), .doneCycles(doneCycles), .donePc(donePc)
  );

  assign busRead  = strb.busRead;
  assign busWrite = 1'b0;

  // R10: the completion pulse never overlaps a bus cycle
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busRead || $past(strb.capture));

endmodule

// File: tb/bitBranchSeq_test.sv
module bitBranchSeq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        startValid = 1'b0;
  logic [7:0]  startOpcode = '0;
  logic [15:0] startPc = '0;
  logic [15:0] busAddr;
  logic        busRead, busWrite, busy, done;
  logic [7:0]  busRdata = '0;
  logic [2:0]  doneCycles;
  logic [15:0] donePc;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [7:0]  mem [int];
  logic [15:0] addrQ [$];
  logic [2:0]  cycQ [$];
  logic [15:0] pcQ [$];
  logic        prevDone = 1'b0;

  always #2 clk = ~clk;

  bitBranchSeq uut (
    .clk(clk), .rst(rst), .startValid(startValid), .startOpcode(startOpcode),
    .startPc(startPc), .busAddr(busAddr), .busRead(busRead), .busWrite(busWrite),
    .busRdata(busRdata), .busy(busy), .done(done), .doneCycles(doneCycles),
    .donePc(donePc)
  );

  function automatic logic [7:0] rdMem(input logic [15:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 8'hEA;
  endfunction

  // monitor: check every read and every completion against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (busRead) begin
        busRdata = rdMem(busAddr);
        checks++;
        if (addrQ.size() == 0) begin
          errors++;
          $display("FAIL R2 R9: unexpected read at %h, expected none", busAddr);
        end else begin
          logic [15:0] ea;
          ea = addrQ.pop_front();
          if (busAddr !== ea || busWrite !== 1'b0) begin
            errors++;
            $display("FAIL R3 R6 R7 R9: addr %h wr %b, expected addr %h wr 0", busAddr, busWrite, ea);
          end
        end
      end
      if (!busRead && busy) begin
        checks++; errors++;
        $display("FAIL R9: busy without read, got 0 expected 1");
      end
      if (done) begin
        checks++;
        if (cycQ.size() == 0) begin
          errors++;
          $display("FAIL R2 R10: unexpected done, expected none");
        end else begin
          logic [2:0]  ec;
          logic [15:0] ep;
          ec = cycQ.pop_front();
          ep = pcQ.pop_front();
          if (doneCycles !== ec || donePc !== ep || addrQ.size() != 0) begin
            errors++;
            $display("FAIL R4 R5 R6 R7 R8: cycles %0d pc %h pending %0d, expected cycles %0d pc %h pending 0",
                     doneCycles, donePc, addrQ.size(), ec, ep);
          end
        end
      end
      if (prevDone) begin
        checks++;
        if (done) begin
          errors++;
          $display("FAIL R10: done %b, expected 0", done);
        end
      end
      prevDone = done;
    end
  end

  // driver: load memory, push expected reads and result, pulse start
  task automatic runOp(input logic [7:0] op, input logic [15:0] pc,
                       input logic [7:0] zp, input logic [7:0] data,
                       input logic [7:0] off);
    logic        tk;
    logic [15:0] fall, tgt;
    int          cyc;
    mem[int'(pc)]              = zp;
    mem[int'(pc + 16'd1)]      = off;
    mem[int'({8'h00, zp})]     = data;
    tk   = (data[op[6:4]] == op[7]);
    fall = pc + 16'd2;
    tgt  = fall + {{8{off[7]}}, off};
    addrQ.push_back(pc);
    addrQ.push_back({8'h00, zp});
    addrQ.push_back({8'h00, zp});
    addrQ.push_back(pc + 16'd1);
    if (!tk) begin
      cyc = 5;
      pcQ.push_back(fall);
    end else begin
      addrQ.push_back(fall);
      cyc = 6;
      if (tgt[15:8] != fall[15:8]) begin
        addrQ.push_back(fall);
        cyc = 7;
      end
      pcQ.push_back(tgt);
    end
    cycQ.push_back(3'(cyc));
    @(negedge clk);
    startValid  = 1'b1;
    startOpcode = op;
    startPc     = pc;
    @(negedge clk);
    startValid  = 1'b0;
    repeat (cyc + 1) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    checks++;
    if (busRead !== 1'b0 || busWrite !== 1'b0 || busy !== 1'b0 || done !== 1'b0) begin
      errors++;
      $display("FAIL R1: rd %b wr %b busy %b done %b, expected all 0", busRead, busWrite, busy, done);
    end

    // R2: non-matching opcodes are ignored
    foreach (startOpcode[i]) begin end
    for (int k = 0; k < 3; k++) begin
      startValid  = 1'b1;
      startOpcode = (k == 0) ? 8'h07 : (k == 1) ? 8'h8E : 8'hF0;
      startPc     = 16'h1234;
      @(negedge clk);
      startValid  = 1'b0;
      repeat (2) @(negedge clk);
      checks++;
      if (busy !== 1'b0 || busRead !== 1'b0) begin
        errors++;
        $display("FAIL R2: busy %b rd %b, expected 0 0", busy, busRead);
      end
    end

    runOp(8'h0F, 16'h1000, 8'h10, 8'hFE, 8'h10);  // R4 R6 taken same page
    runOp(8'h8F, 16'h2000, 8'h11, 8'hFE, 8'h10);  // R5 not taken
    runOp(8'hFF, 16'h30F0, 8'h12, 8'h80, 8'h20);  // R7 forward crossing
    runOp(8'h7F, 16'h4005, 8'h13, 8'h7F, 8'h80);  // R7 R8 backward crossing
    runOp(8'h5F, 16'h4800, 8'h14, 8'h20, 8'h05);  // R5 reset-variant not taken
    runOp(8'hDF, 16'hFFF0, 8'h40, 8'h20, 8'h7F);  // R8 wrap past 0xFFFF
    runOp(8'hAF, 16'h5010, 8'h15, 8'h04, 8'hFE);  // R6 R8 negative same page
    // R4: every bit under both polarities
    for (int b = 0; b < 8; b++) begin
      runOp({1'b1, 3'(b), 4'hF}, 16'h6000 + 16'(b * 16), 8'(8'h20 + b), 8'(1 << b), 8'h05);
      runOp({1'b0, 3'(b), 4'hF}, 16'h7000 + 16'(b * 16), 8'(8'h30 + b), 8'(1 << b), 8'h05);
    end

    checks++;
    if (addrQ.size() != 0 || cycQ.size() != 0) begin
      errors++;
      $display("FAIL R10: pending reads %0d results %0d, expected 0 0", addrQ.size(), cycQ.size());
    end
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

endmodule